// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM with a shared data bus of four 8-bit byte lanes and a parameterized word count. Every control, address and data input is registered on the rising clock edge. An access starts when one of two active-low start strobes is asserted. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls presented in the same cycle. After the start, an active-low advance input steps an internal two-bit counter. The counter walks the low two address bits in linear or interleaved order and wraps within the four-word group.

Reads pass through an access register, a registered array read and an output register. A burst therefore returns its first word after two further clock edges and then one word per edge (3-1-1-1). The data bus is modelled as a data-out vector plus a drive flag. An extra pipelined enable keeps the bus driven for one more cycle after a deselect. The output enable gates the drive flag combinationally. A write blanks the bus, and the bus stays blank until a strobe starts a new read.

The interface is a set of plain memory pins with no valid/ready handshake. The block accepts one access per cycle and never applies back-pressure.

Top module: `sram_pipe_burst`

## Requirements
- R1: Address and chip select are taken only in a cycle where either start strobe is low. If a strobe is low while chip_sel_n is high, the cycle is a deselect: it ends any burst, writes nothing and starts no read. Without a strobe, addr_in is ignored.
- R2: A start with cpu_strobe_n low is always a read, and the write controls are ignored in that cycle. This holds even when ctl_strobe_n is also low.
- R3: Beat k of a burst (k = 0..3, counted by advance cycles) keeps address bits above bit 1 from the base. With burst_interleave = 0, the low two bits are base[1:0] + k mod 4. With burst_interleave = 1, they are base[1:0] XOR k.
- R4: Read data for an access registered on edge n is on rdata, with rdata_drive high, after edge n+2. After edge n+1 it is not yet driven. Consecutive beats then follow one per edge.
- R5: With no strobe and advance_n high during an active burst, the same address is accessed again (the burst is suspended).
- R6: ctl_strobe_n low during a burst restarts the burst at beat 0 from the newly presented address.
- R7: With all_wr_n low, a write cycle writes all four lanes, whatever lane_wr_en_n and lane_sel_n are.
- R8: With all_wr_n high and lane_wr_en_n low, lane i (data bits 8i+7..8i) is written only when lane_sel_n[i] is low. Unselected lanes keep their old contents.
- R9: After a deselect, rdata_drive stays high one cycle beyond the last read word, with that word held on rdata. It then drops.
- R10: out_en_n high forces rdata_drive low combinationally, within the same clock cycle.
- R11: From the edge that registers a write, rdata_drive is low whatever out_en_n is. It stays low, even through later burst reads, until a strobe starts a new read.
- R12: After reset the bus is undriven and no burst is active, so advance and write inputs have no effect until a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr_in | input | AW = clog2(DEPTH) | Word address, taken at a start |
| chip_sel_n | input | 1 | Active-low chip select, taken at a start |
| cpu_strobe_n | input | 1 | Active-low start strobe, always a read |
| ctl_strobe_n | input | 1 | Active-low start strobe, read or write |
| advance_n | input | 1 | Active-low burst advance |
| burst_interleave | input | 1 | 1 = interleaved burst order, 0 = linear |
| all_wr_n | input | 1 | Active-low write of all lanes |
| lane_wr_en_n | input | 1 | Active-low enable for per-lane writes |
| lane_sel_n | input | 4 | Active-low lane selects, bit i = lane i |
| out_en_n | input | 1 | Active-low asynchronous output enable |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data from the output register |
| rdata_drive | output | 1 | High when the bus is driven |

## Verification
The bench builds the block with DEPTH = 64 and the one-cycle deselect tail enabled. The small array lets an initial set of full-width burst writes fill every word. Random bursts then revisit words often, so lane merges and overwrites are read back many times. Because the burst order is a pin, one build covers both linear and interleaved orders, with suspends and restarts placed at random beats.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  // Low-two-bit offset of a burst beat from its base.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       interleave);
    return interleave ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_burst_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic          step,
  input  logic          interleave,
  output logic [AW-1:0] next_addr
);

  logic [AW-1:0] base_q, base_n;
  logic [1:0]    cnt_q, cnt_n;

  always_comb begin
    base_n    = load ? base_in : base_q;
    cnt_n     = load ? 2'd0 : cnt_q + 2'(step);
    next_addr = {base_n[AW-1:2], beat_offset(base_n[1:0], cnt_n, interleave)};
  end

  always_ff @(posedge clk) begin
    base_q <= base_n;
    cnt_q  <= cnt_n;
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [AW-1:0]    acc_addr,
  input  logic [DW-1:0]    acc_data,
  input  logic [LANES-1:0] acc_mask,
  output logic [DW-1:0]    rd_data,
  output logic             rd_vld
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_lane;

    always_ff @(posedge clk) begin
      if (acc_vld && acc_wr && acc_mask[g])
        mem[acc_addr] <= acc_data[g*LANE_W +: LANE_W];
      if (acc_vld && !acc_wr)
        rd_lane <= mem[acc_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_lane;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= acc_vld & ~acc_wr;
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int DW         = 32,
  parameter int DRIVE_TAIL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic          out_en_n,
  input  logic          blank,
  output logic [DW-1:0] dout,
  output logic          drive_raw,
  output logic          drive
);

  logic vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) dout <= in_data;
  end

  if (DRIVE_TAIL != 0) begin : g_tail
    logic tail_q;
    always_ff @(posedge clk) begin
      if (!rst_n) tail_q <= 1'b0;
      else        tail_q <= vld_q & ~in_vld;
    end
    assign drive_raw = vld_q | tail_q;
  end else begin : g_no_tail
    assign drive_raw = vld_q;
  end

  assign drive = drive_raw & ~out_en_n & ~blank;

endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
  import sram_burst_pkg::*;
#(
  parameter int  DEPTH      = 256,
  parameter int  LANE_W     = 8,
  parameter int  LANES      = 4,
  parameter int  DRIVE_TAIL = 1,
  localparam int AW         = $clog2(DEPTH),
  localparam int DW         = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_in,
  input  logic             chip_sel_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             advance_n,
  input  logic             burst_interleave,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             out_en_n,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_drive
);

  logic             cpu_start, start_any, acc_load, acc_step;
  logic             op_vld_n, op_wr_n, wr_seen;
  logic [LANES-1:0] wr_mask;
  logic [AW-1:0]    next_addr;

  logic             burst_q, wr_hold_q;
  logic             op_vld_q, op_wr_q;
  logic [AW-1:0]    op_addr_q;
  logic [DW-1:0]    op_data_q;
  logic [LANES-1:0] op_mask_q;

  logic [DW-1:0]    rd_data;
  logic             rd_vld;
  logic             drive_raw;

  // Decode of the cycle's command
  always_comb begin
    cpu_start = ~cpu_strobe_n;
    start_any = cpu_start | ~ctl_strobe_n;
    if (!all_wr_n)          wr_mask = '1;
    else if (!lane_wr_en_n) wr_mask = ~lane_sel_n;
    else                    wr_mask = '0;
    wr_seen  = |wr_mask;
    acc_load = start_any & ~chip_sel_n;
    acc_step = ~start_any & burst_q & ~advance_n;
    op_vld_n = acc_load | (~start_any & burst_q);
    op_wr_n  = op_vld_n & wr_seen & ~cpu_start;
  end

  sram_burst_addr #(.AW(AW)) u_addr (
    .clk        (clk),
    .load       (acc_load),
    .base_in    (addr_in),
    .step       (acc_step),
    .interleave (burst_interleave),
    .next_addr  (next_addr)
  );

  // Control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_q   <= 1'b0;
      wr_hold_q <= 1'b0;
      op_vld_q  <= 1'b0;
      op_wr_q   <= 1'b0;
    end else begin
      if (start_any) burst_q <= ~chip_sel_n;
      if (op_wr_n)       wr_hold_q <= 1'b1;
      else if (acc_load) wr_hold_q <= 1'b0;
      op_vld_q <= op_vld_n;
      op_wr_q  <= op_wr_n;
    end
  end

  // Access register
  always_ff @(posedge clk) begin
    if (op_vld_n) begin
      op_addr_q <= next_addr;
      op_data_q <= wdata;
      op_mask_q <= wr_mask;
    end
  end

  sram_lane_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_vld  (op_vld_q),
    .acc_wr   (op_wr_q),
    .acc_addr (op_addr_q),
    .acc_data (op_data_q),
    .acc_mask (op_mask_q),
    .rd_data  (rd_data),
    .rd_vld   (rd_vld)
  );

  sram_out_stage #(.DW(DW), .DRIVE_TAIL(DRIVE_TAIL)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (rd_vld),
    .in_data   (rd_data),
    .out_en_n  (out_en_n),
    .blank     (wr_hold_q),
    .dout      (rdata),
    .drive_raw (drive_raw),
    .drive     (rdata_drive)
  );

endmodule

// File: rtl/sram_pipe_burst_chk.sv
module sram_pipe_burst_chk #(
  parameter int AW         = 8,
  parameter int DRIVE_TAIL = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_strobe_n,
  input logic          ctl_strobe_n,
  input logic          chip_sel_n,
  input logic          advance_n,
  input logic          all_wr_n,
  input logic          out_en_n,
  input logic          rdata_drive,
  input logic          op_vld_q,
  input logic          op_wr_q,
  input logic [AW-1:0] op_addr_q,
  input logic          rd_vld,
  input logic          drive_raw
);

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cpu_strobe_n || !ctl_strobe_n) && chip_sel_n) |=> !op_vld_q);

  p_cpu_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !chip_sel_n) |=> (op_vld_q && !op_wr_q));

  p_high_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n && ctl_strobe_n && op_vld_q) |=> $stable(op_addr_q[AW-1:2]));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cpu_strobe_n && !chip_sel_n, 3) |-> drive_raw);

  p_suspend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n && ctl_strobe_n && advance_n && op_vld_q) |=>
      (op_vld_q && $stable(op_addr_q)));

  if (DRIVE_TAIL != 0) begin : g_tail_chk
    p_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_vld, 2) |-> drive_raw);
  end else begin : g_plain_chk
    p_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_vld) |-> drive_raw);
  end

  p_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_drive);

  p_write_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && cpu_strobe_n && !chip_sel_n && !all_wr_n) |=> !rdata_drive);

endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(.AW(AW), .DRIVE_TAIL(DRIVE_TAIL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_strobe_n (cpu_strobe_n),
  .ctl_strobe_n (ctl_strobe_n),
  .chip_sel_n   (chip_sel_n),
  .advance_n    (advance_n),
  .all_wr_n     (all_wr_n),
  .out_en_n     (out_en_n),
  .rdata_drive  (rdata_drive),
  .op_vld_q     (op_vld_q),
  .op_wr_q      (op_wr_q),
  .op_addr_q    (op_addr_q),
  .rd_vld       (rd_vld),
  .drive_raw    (drive_raw)
);

// File: tb/tb_sram_pipe_burst.sv
`timescale 1ns/1ps
module tb_sram_pipe_burst;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          chip_sel_n, cpu_strobe_n, ctl_strobe_n, advance_n;
  logic          burst_interleave, all_wr_n, lane_wr_en_n, out_en_n;
  logic [3:0]    lane_sel_n;
  logic [31:0]   wdata, rdata;
  logic          rdata_drive;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] model [DEPTH];

  always #2.5 clk = ~clk;

  sram_pipe_burst #(.DEPTH(DEPTH), .DRIVE_TAIL(1)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .chip_sel_n(chip_sel_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .advance_n(advance_n), .burst_interleave(burst_interleave),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; chip_sel_n = 1'b0;
    advance_n = 1'b1; all_wr_n = 1'b1; lane_wr_en_n = 1'b1;
    lane_sel_n = 4'hF; out_en_n = 1'b0;
  endtask

  function automatic logic [AW-1:0] beat(logic [AW-1:0] b, logic [1:0] k, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] m);
    logic [31:0] r;
    r = o;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  // Four-beat burst write from the controller strobe, then deselect.
  task automatic write_burst(logic [AW-1:0] base, logic glob, logic [3:0] lanes,
                             logic il, string tag);
    logic [3:0]    m;
    logic [AW-1:0] a;
    m = glob ? 4'hF : ~lanes;
    burst_interleave = il;
    for (int k = 0; k < 4; k++) begin
      if (k == 0) begin ctl_strobe_n = 1'b0; addr_in = base; advance_n = 1'b1; end
      else        begin ctl_strobe_n = 1'b1; advance_n = 1'b0; end
      all_wr_n     = ~glob;
      lane_wr_en_n = glob ? 1'($urandom % 2) : 1'b0;
      lane_sel_n   = lanes;
      wdata        = $urandom;
      a = beat(base, 2'(k), il);
      tick();
      model[a] = merge(model[a], wdata, m);
      chk($sformatf("R11 bus blank during write beat%0d", k), {31'b0, rdata_drive}, 32'd0);
    end
    idle();
    ctl_strobe_n = 1'b0; chip_sel_n = 1'b1;
    tick();
    idle();
    if (tag.len() == 0) chk("R11", {31'b0, rdata_drive}, 32'd0);
  endtask

  // Burst read: start by the processor strobe, four continuation edges
  // (adv bit j-1 for edge j, optional controller restart), deselect, tail.
  task automatic read_seq(logic [AW-1:0] base, logic [3:0] adv, int rs_idx,
                          logic [AW-1:0] rs_base, logic il, string tag);
    logic [AW-1:0] ea [5];
    logic [AW-1:0] cb;
    logic [1:0]    cnt;
    cb = base; cnt = 2'd0; ea[0] = base;
    for (int j = 1; j <= 4; j++) begin
      if (j == rs_idx) begin cb = rs_base; cnt = 2'd0; end
      else if (adv[j-1]) cnt = cnt + 2'd1;
      ea[j] = beat(cb, cnt, il);
    end
    idle();
    burst_interleave = il;
    cpu_strobe_n = 1'b0; addr_in = base;
    tick();
    for (int j = 1; j <= 4; j++) begin
      idle();
      if (j == rs_idx) begin ctl_strobe_n = 1'b0; addr_in = rs_base; end
      else advance_n = ~adv[j-1];
      addr_in = (j == rs_idx) ? rs_base : AW'($urandom);
      tick();
      if (j == 1) chk({tag, " R4 not yet driven"}, {31'b0, rdata_drive}, 32'd0);
      else begin
        chk($sformatf("%s R4 drive beat%0d", tag, j-2), {31'b0, rdata_drive}, 32'd1);
        chk($sformatf("%s R3 data beat%0d", tag, j-2), rdata, model[ea[j-2]]);
      end
    end
    idle();
    ctl_strobe_n = 1'b0; chip_sel_n = 1'b1;
    tick();
    chk({tag, " R4 data beat3"}, rdata, model[ea[3]]);
    idle();
    tick();
    chk({tag, " R4 data beat4"}, rdata, model[ea[4]]);
    tick();
    chk({tag, " R9 tail drive"}, {31'b0, rdata_drive}, 32'd1);
    chk({tag, " R9 tail data"}, rdata, model[ea[4]]);
    out_en_n = 1'b1;
    #1;
    chk({tag, " R10 oe high"}, {31'b0, rdata_drive}, 32'd0);
    out_en_n = 1'b0;
    #0.5;
    chk({tag, " R10 oe low"}, {31'b0, rdata_drive}, 32'd1);
    tick();
    chk({tag, " R9 tail over"}, {31'b0, rdata_drive}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_d;
    seed_d = $urandom(32'h1d2c3b);
    idle();
    burst_interleave = 1'b0; addr_in = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    chk("R12 reset bus undriven", {31'b0, rdata_drive}, 32'd0);

    // Fill the array with full-width writes
    for (int i = 0; i < DEPTH / 4; i++) write_burst(AW'(i * 4), 1'b1, 4'h0, 1'b0, "R7");

    read_seq(6'd0,  4'hF, 0, '0, 1'b0, "R3 linear");
    read_seq(6'd13, 4'hF, 0, '0, 1'b0, "R3 linear wrap");
    read_seq(6'd13, 4'hF, 0, '0, 1'b1, "R3 interleave");
    read_seq(6'd8,  4'b0101, 0, '0, 1'b0, "R5 suspend");
    read_seq(6'd20, 4'hF, 2, 6'd41, 1'b0, "R6 restart");

    write_burst(6'd32, 1'b0, 4'b1010, 1'b0, "R8");
    read_seq(6'd32, 4'hF, 0, '0, 1'b0, "R8 lanes");

    // R2: write controls with the processor strobe are ignored
    idle();
    cpu_strobe_n = 1'b0; ctl_strobe_n = 1'b0; all_wr_n = 1'b0;
    addr_in = 6'd44; wdata = 32'hDEAD_BEEF;
    tick();
    idle(); ctl_strobe_n = 1'b0; chip_sel_n = 1'b1;
    tick();
    idle(); repeat (3) tick();
    read_seq(6'd44, 4'hF, 0, '0, 1'b0, "R2 no write");

    // R1: deselect strobe writes nothing; advance without a burst does nothing
    idle();
    ctl_strobe_n = 1'b0; chip_sel_n = 1'b1; all_wr_n = 1'b0;
    addr_in = 6'd48; wdata = 32'h1234_5678;
    tick();
    idle(); advance_n = 1'b0; all_wr_n = 1'b0; wdata = 32'h0BAD_F00D;
    repeat (2) tick();
    chk("R1 no drive without burst", {31'b0, rdata_drive}, 32'd0);
    idle();
    read_seq(6'd48, 4'hF, 0, '0, 1'b0, "R1 unchanged");

    // R11: after a write, continued burst reads stay undriven
    idle();
    ctl_strobe_n = 1'b0; all_wr_n = 1'b0; addr_in = 6'd52; wdata = 32'hA5A5_5A5A;
    tick();
    model[52] = 32'hA5A5_5A5A;
    chk("R11 blank after write", {31'b0, rdata_drive}, 32'd0);
    idle(); advance_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk($sformatf("R11 blank on burst read %0d", k), {31'b0, rdata_drive}, 32'd0);
    end
    idle(); ctl_strobe_n = 1'b0; chip_sel_n = 1'b1;
    tick();
    idle();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R11 blank after deselect", {31'b0, rdata_drive}, 32'd0);
    end
    read_seq(6'd52, 4'hF, 0, '0, 1'b0, "R11 read restores");

    // R12: reset ends activity; inputs ignored until a strobe
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    chk("R12 undriven after reset", {31'b0, rdata_drive}, 32'd0);
    advance_n = 1'b0; all_wr_n = 1'b0; wdata = 32'h0; addr_in = 6'd56;
    repeat (3) tick();
    chk("R12 no drive without strobe", {31'b0, rdata_drive}, 32'd0);
    idle();
    read_seq(6'd56, 4'hF, 0, '0, 1'b0, "R12 unchanged");

    // Random mix
    for (int it = 0; it < 80; it++) begin
      if ($urandom % 3 == 0)
        write_burst(AW'($urandom), 1'($urandom % 2), 4'($urandom % 15),
                    1'($urandom % 2), "R8 rand");
      else
        read_seq(AW'($urandom), 4'($urandom), int'($urandom % 5), AW'($urandom),
                 1'($urandom % 2), "R5 R6 rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule